// File: doc/BRIEF.md
# Serial Status Word Readout Port

This block is a read-only serial slave that lets a host fetch a 16-bit status word over a four-wire style serial link. The host pulls the active-low select line low, then toggles the serial clock. The block returns one status bit per rising clock edge, most significant bit first. The data pin is driven only while select is low. At the pad it is modelled as a data bit plus a separate output enable, so that the pad cell can build the tri-state driver.

Both serial inputs are brought into the system clock domain by multi-stage synchronisers, and all edge detection happens there. The status word is captured when select falls, so a flag that changes mid-frame cannot tear the word being read. A frame counts as a valid read only if it holds exactly one clock per status bit. A valid frame that ends with select rising produces a one-cycle strobe. The flag logic uses this strobe to clear the flags it has latched. Frames that are too short or too long produce no strobe.

Top module: `status_spi_readout`

## Requirements
- R1: While the synchronised select is high, `spi_dout_oe` is 0, which means the data pin is high-impedance. It returns to 0 on the third system clock edge after select rises.
- R2: On the third system clock edge after select falls, `spi_dout_oe` becomes 1 and `spi_dout` is 0, and both stay that way until the first serial clock rising edge.
- R3: Each serial clock rising edge inside a frame presents the next bit of the captured word on `spi_dout`, most significant bit first. Bit value 1 means the flag is set (active high). Clocks beyond the word length present 0.
- R4: The word shifted out is the value of `status_word` when select fell. Changes to `status_word` during the frame have no effect on it.
- R5: A frame with exactly `WORD_W` serial clock rising edges, followed by select rising, gives exactly one `read_done` pulse, one system clock wide.
- R6: A frame with any other number of rising edges (0, 1, `WORD_W`-1, `WORD_W`+1 or more) gives no `read_done` pulse. The internal bit count saturates at `WORD_W`+1.
- R7: Serial clock edges while select is high change neither output and are not counted toward the next frame.
- R8: A synchronous active-high `rst` forces `spi_dout_oe`=0, `spi_dout`=0 and `read_done`=0, and leaves the port idle with select treated as high.
- R9: Output response to a pin change occurs on the (`SYNC_STAGES`+1)-th system clock edge after it: the output is unchanged after `SYNC_STAGES` edges and has changed after one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| status_word | input | WORD_W | Live status flags from the flag logic |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_csn | input | 1 | Active-low frame select from the host, asynchronous |
| spi_dout | output | 1 | Serial data toward the host, valid when enabled |
| spi_dout_oe | output | 1 | Drive enable for the data pad, 0 means high-impedance |
| read_done | output | 1 | One-cycle strobe after a valid complete read |

## Verification
A corrupted bit counter shows at the ports only at the end of a frame, as a missing or spurious `read_done` strobe in the third system cycle after select rises. The bench therefore ends frames of every interesting length and counts strobes. A shift register that is misloaded or shifts in the wrong direction shows on the very next serial rising edge as a wrong data bit. A lost frame flag shows as an enable that stays low after select falls, or that stays high after select rises.

// File: rtl/status_spi_readout_pkg.sv
package status_spi_readout_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic clk_rise;
  } spi_evt_t;
endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sro_edge.sv
module sro_edge
  import status_spi_readout_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     csn_s,
  input  logic     sclk_s,
  output spi_evt_t evt
);
  logic csn_q, sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      csn_q  <= csn_s;
      sclk_q <= sclk_s;
    end
  end

  // clock edges only count once select has been low for a full cycle
  always_comb begin
    evt.cs_fall  = csn_q & ~csn_s;
    evt.cs_rise  = ~csn_q & csn_s;
    evt.clk_rise = ~sclk_q & sclk_s & ~csn_s & ~csn_q;
  end
endmodule

// File: rtl/sro_shifter.sv
module sro_shifter
  import status_spi_readout_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_evt_t          evt,
  input  logic [WORD_W-1:0] load_word,
  output logic              dout,
  output logic              dout_oe
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else if (evt.cs_fall) begin
      shreg   <= load_word;
      dout    <= 1'b0;
      dout_oe <= 1'b1;
    end else if (evt.clk_rise) begin
      dout    <= shreg[WORD_W-1];
      shreg   <= {shreg[WORD_W-2:0], 1'b0};
    end else if (evt.cs_rise) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sro_counter.sv
module sro_counter
  import status_spi_readout_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  spi_evt_t         evt,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WORD_W + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= evt.cs_rise && (bit_cnt == FULL);
      if (evt.cs_fall)
        bit_cnt <= '0;
      else if (evt.clk_rise && bit_cnt != LIMIT)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/status_spi_readout.sv
module status_spi_readout
  import status_spi_readout_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] status_word,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  output logic              spi_dout,
  output logic              spi_dout_oe,
  output logic              read_done
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic            csn_s, sclk_s;
  spi_evt_t        evt;
  logic [CNT_W-1:0] bit_cnt;

  assign pin_raw = {spi_csn, spi_sclk};

  // index 1 is select (idles high), index 0 the serial clock (idles low)
  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    sro_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == 1)) u_sync (
      .clk(clk), .rst(rst), .d(pin_raw[g]), .q(pin_s[g])
    );
  end

  assign csn_s  = pin_s[1];
  assign sclk_s = pin_s[0];

  sro_edge u_edge (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sclk_s(sclk_s), .evt(evt)
  );

  sro_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .evt(evt), .load_word(status_word),
    .dout(spi_dout), .dout_oe(spi_dout_oe)
  );

  sro_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .evt(evt), .bit_cnt(bit_cnt), .done(read_done)
  );
endmodule

// File: rtl/status_spi_readout_chk.sv
module status_spi_readout_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             csn_s,
  input logic             spi_dout,
  input logic             spi_dout_oe,
  input logic             read_done,
  input logic [CNT_W-1:0] bit_cnt
);
  // R1
  idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s && $past(csn_s) |-> !spi_dout_oe);

  // R2
  enable_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_dout_oe) |-> !spi_dout);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    read_done |=> !read_done);

  // R6
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    read_done |-> (bit_cnt == CNT_W'(WORD_W)) && csn_s);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W + 1));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s && $past(csn_s) && $past(csn_s, 2) |-> $stable(spi_dout) && !spi_dout);
endmodule

bind status_spi_readout status_spi_readout_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .csn_s(csn_s), .spi_dout(spi_dout),
  .spi_dout_oe(spi_dout_oe), .read_done(read_done), .bit_cnt(bit_cnt)
);

// File: tb/status_spi_readout_test.sv
module status_spi_readout_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int HALF = 4;
  localparam int NV = 8;
  localparam logic [W-1:0] VWORD [NV] = '{16'hA5C3, 16'h8001, 16'hFFFF, 16'h0000,
                                          16'h1234, 16'h7FFE, 16'hC0DE, 16'h5A5A};
  localparam int VCLKS [NV] = '{16, 16, 15, 17, 0, 1, 20, 16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] status_word = '0;
  logic spi_sclk = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_dout, spi_dout_oe, read_done;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int wide = 0;
  logic prev_done = 1'b0;

  status_spi_readout #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .status_word(status_word), .spi_sclk(spi_sclk),
    .spi_csn(spi_csn), .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
    .read_done(read_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (read_done) pulses++;
    if (read_done && prev_done) wide++;
    prev_done <= read_done;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic run_frame(input logic [W-1:0] word, input int n);
    int p0, w0;
    p0 = pulses; w0 = wide;
    status_word = word;
    spi_csn = 1'b0;
    wait_neg(HALF);
    check(spi_dout_oe == 1'b1, "R2 oe after select fall", spi_dout_oe, 1);
    check(spi_dout == 1'b0, "R2 default low", spi_dout, 0);
    status_word = ~word;  // R4: must not reach the shifted word
    for (int i = 0; i < n; i++) begin
      spi_sclk = 1'b1;
      wait_neg(HALF);
      if (i < W)
        check(spi_dout == word[W-1-i], "R3 R4 data bit", spi_dout, int'(word[W-1-i]));
      else
        check(spi_dout == 1'b0, "R3 bit past word", spi_dout, 0);
      spi_sclk = 1'b0;
      wait_neg(HALF);
    end
    spi_csn = 1'b1;
    wait_neg(HALF + 2);
    check(spi_dout_oe == 1'b0, "R1 hi-z after frame", spi_dout_oe, 0);
    if (n == W)
      check(pulses - p0 == 1, "R5 one strobe", pulses - p0, 1);
    else
      check(pulses - p0 == 0, "R6 no strobe", pulses - p0, 0);
    check(wide == w0, "R5 strobe width", wide - w0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    wait_neg(4);
    // R8 reset state
    check(spi_dout_oe == 1'b0, "R8 oe in reset", spi_dout_oe, 0);
    check(spi_dout == 1'b0, "R8 dout in reset", spi_dout, 0);
    check(read_done == 1'b0, "R8 done in reset", read_done, 0);
    rst = 1'b0;
    wait_neg(4);
    check(spi_dout_oe == 1'b0, "R1 idle after reset", spi_dout_oe, 0);

    for (int v = 0; v < NV; v++) run_frame(VWORD[v], VCLKS[v]);

    // R9 latency of select fall
    spi_csn = 1'b0;
    wait_neg(2);
    check(spi_dout_oe == 1'b0, "R9 no change after 2 edges", spi_dout_oe, 0);
    wait_neg(1);
    check(spi_dout_oe == 1'b1, "R9 change on 3rd edge", spi_dout_oe, 1);
    spi_csn = 1'b1;
    wait_neg(2);
    check(spi_dout_oe == 1'b1, "R9 still on after 2 edges", spi_dout_oe, 1);
    wait_neg(1);
    check(spi_dout_oe == 1'b0, "R1 R9 off on 3rd edge", spi_dout_oe, 0);
    wait_neg(4);

    // R7 clocks while idle are ignored and not counted
    begin
      int p0;
      p0 = pulses;
      for (int t = 0; t < 5; t++) begin
        spi_sclk = 1'b1; wait_neg(HALF);
        check(spi_dout_oe == 1'b0 && spi_dout == 1'b0, "R7 idle outputs",
              {spi_dout_oe, spi_dout}, 0);
        spi_sclk = 1'b0; wait_neg(HALF);
      end
      check(pulses == p0, "R7 no strobe idle", pulses - p0, 0);
    end
    run_frame(16'h9C3A, W);

    // R8 reset in mid-frame
    status_word = 16'hFFFF;
    spi_csn = 1'b0;
    wait_neg(HALF);
    spi_sclk = 1'b1;
    wait_neg(HALF);
    rst = 1'b1;
    spi_csn = 1'b1;
    spi_sclk = 1'b0;
    wait_neg(1);
    check(spi_dout_oe == 1'b0, "R8 oe after reset", spi_dout_oe, 0);
    check(spi_dout == 1'b0, "R8 dout after reset", spi_dout, 0);
    wait_neg(3);
    rst = 1'b0;
    wait_neg(6);
    check(read_done == 1'b0 && spi_dout_oe == 1'b0, "R8 idle after reset",
          {read_done, spi_dout_oe}, 0);
    run_frame(16'h0F0F, W);

    summary();
  end
endmodule